// File: doc/BRIEF.md
# Gated-Clock Serial Word Shifter

This block moves one parallel word at a time over a single serial data line in each direction, with no frame sync. The bit clock exists only while a word is in flight. A word offered on the transmit handshake is shifted out MSB first and, in the same window, a word is shifted in from the serial input and presented with a one-cycle valid strobe. Between words the clock line rests at its idle level, so data leaves in bursts. Every word is a standalone transfer: there is no slot counting and no frame-rate division.

In internal-clock mode the block makes the bit clock itself. Each half period lasts h system cycles, where h is `cfg_half_div`, or 1 when that field is zero. Exactly `WORD_W` pulses are produced per word. In external-clock mode the block leaves its clock output idle and follows an incoming bit clock. That clock passes through a two-flop synchronizer and an edge detector, and must run at no more than a quarter of the system clock rate. One polarity bit sets three things together. With 0, the clock idles low, data is launched on the rising (leading) edge and sampled on the falling (trailing) edge. With 1, all three are inverted. Polarity, mode and divider are captured when a word is accepted.

The controller has four states. ST_IDLE accepts a word and moves to ST_INT_REST (internal) or ST_EXT_RUN (external). ST_INT_REST makes a leading edge when its timer expires and moves to ST_INT_ACT. ST_INT_ACT makes a trailing edge when its timer expires, then returns to ST_INT_REST, or to ST_IDLE after the last bit. ST_EXT_RUN returns to ST_IDLE on the trailing edge of the last bit.

Top module: `gated_serial_port`

## Requirements
- R1: After reset, tx_ready is 1, rx_valid is 0, sd_o is 0 and sck_o is 0.
- R2: A word is accepted in a cycle where tx_valid and tx_ready are both 1. tx_ready is 0 from the next cycle until the transfer ends. A word held on tx_valid during a transfer is not lost and is sent as the next transfer.
- R3: In internal mode each word produces exactly WORD_W clock pulses. Each active half and each idle half between pulses lasts h system cycles, with h = cfg_half_div, or 1 when cfg_half_div is 0.
- R4: While no transfer is running, sck_o rests at cfg_pol: low for 0, high for 1.
- R5: sd_o changes only on a leading edge, meaning the clock leaving its idle level: rising for polarity 0, falling for polarity 1. sd_i is sampled on the trailing edge.
- R6: Transmit bits go out MSB first. The first bit sampled on sd_i lands in rx_data[WORD_W-1].
- R7: rx_valid is high for exactly one cycle, right after the last bit is sampled, and rx_data carries the received word in that cycle.
- R8: In external mode sck_o stays at its idle level. Each leading edge of sck_i launches the next bit, each trailing edge samples sd_i, and the word completes after WORD_W trailing edges.
- R9: sck_i edges while no word is accepted are ignored: no rx_valid, tx_ready stays 1, and the next external word transfers correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ext | input | 1 | 1 selects the external bit clock, 0 the internal one |
| cfg_pol | input | 1 | Clock polarity and idle level |
| cfg_half_div | input | DIV_W | Internal half period in system cycles (0 treated as 1) |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block can accept a word |
| rx_data | output | WORD_W | Received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sck_o | output | 1 | Generated bit clock |
| sck_i | input | 1 | Incoming bit clock |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
The bench builds the block with WORD_W = 8 and DIV_W = 4, so a word takes a few dozen cycles. The full divider range, from the zero clamp to the largest half period of 15, fits in a short run. The vector table covers both modes and both polarities. This exposes pulse count and pulse width, bit order, and the relation between the launch edge and the sample edge. Directed cases cover a word held on the handshake during a transfer, and idle-time edges on the external clock.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INT_REST,
        ST_INT_ACT,
        ST_EXT_RUN
    } gsp_state_e;
endpackage

// File: rtl/gsp_sync_edge.sv
module gsp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic pol,
    output logic lead,
    output logic trail
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    logic moved;
    assign moved = chain_q[STAGES-1] != chain_q[STAGES];
    assign lead  = moved && (chain_q[STAGES-1] != pol);
    assign trail = moved && (chain_q[STAGES-1] == pol);
endmodule

// File: rtl/gsp_tx_shift.sv
module gsp_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    output logic         bit_o
);
    logic [W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            bit_o  <= 1'b0;
        end else if (load) begin
            word_q <= load_val;
        end else if (shift_en) begin
            bit_o  <= word_q[W-1];
            word_q <= {word_q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/gsp_rx_shift.sv
module gsp_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         in_bit,
    output logic [W-1:0] word_o
);
    logic [W-2:0] hist_q;

    assign word_o = {hist_q, in_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= word_o[W-2:0];
    end
endmodule

// File: rtl/gated_serial_port.sv
module gated_serial_port
    import gsp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ext,
    input  logic              cfg_pol,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sck_o,
    input  logic              sck_i,
    output logic              sd_o,
    input  logic              sd_i
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    gsp_state_e        state_q, state_d;
    logic              pol_q, ext_q, sck_q, rx_valid_q;
    logic [DIV_W-1:0]  half_q, timer_q, half_eff_m1;
    logic [CNT_W-1:0]  bit_q;
    logic [WORD_W-1:0] rx_data_q, rx_word;
    logic              ext_lead, ext_trail;

    logic accept, timer_done, last_bit, lead_ev, trail_ev;
    assign accept      = tx_valid && (state_q == ST_IDLE);
    assign timer_done  = (timer_q == '0);
    assign last_bit    = (bit_q == LAST_IDX);
    assign half_eff_m1 = (cfg_half_div == '0) ? '0 : cfg_half_div - 1'b1;
    assign lead_ev  = ((state_q == ST_INT_REST) && timer_done) ||
                      ((state_q == ST_EXT_RUN) && ext_lead);
    assign trail_ev = ((state_q == ST_INT_ACT) && timer_done) ||
                      ((state_q == ST_EXT_RUN) && ext_trail);

    gsp_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sck_i), .pol(pol_q),
        .lead(ext_lead), .trail(ext_trail)
    );

    gsp_tx_shift #(.W(WORD_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(tx_data),
        .shift_en(lead_ev), .bit_o(sd_o)
    );

    gsp_rx_shift #(.W(WORD_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(trail_ev), .in_bit(sd_i),
        .word_o(rx_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = cfg_ext ? ST_EXT_RUN : ST_INT_REST;
            ST_INT_REST: if (timer_done) state_d = ST_INT_ACT;
            ST_INT_ACT:  if (timer_done) state_d = last_bit ? ST_IDLE : ST_INT_REST;
            ST_EXT_RUN:  if (ext_trail && last_bit) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q      <= 1'b0;
            ext_q      <= 1'b0;
            half_q     <= '0;
            timer_q    <= '0;
            bit_q      <= '0;
            sck_q      <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sck_q <= cfg_pol;
                    if (accept) begin
                        pol_q   <= cfg_pol;
                        ext_q   <= cfg_ext;
                        half_q  <= half_eff_m1;
                        timer_q <= half_eff_m1;
                        bit_q   <= '0;
                    end
                end
                ST_INT_REST: begin
                    if (timer_done) begin
                        sck_q   <= ~pol_q;
                        timer_q <= half_q;
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                ST_INT_ACT: begin
                    if (timer_done) begin
                        sck_q   <= pol_q;
                        timer_q <= half_q;
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                ST_EXT_RUN: begin
                end
                default: begin
                end
            endcase
            if (trail_ev) begin
                bit_q <= bit_q + 1'b1;
                if (last_bit) begin
                    rx_valid_q <= 1'b1;
                    rx_data_q  <= rx_word;
                end
            end
        end
    end

    assign tx_ready = (state_q == ST_IDLE);
    assign sck_o    = sck_q;
    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;
endmodule

// File: rtl/gsp_checker.sv
module gsp_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic sck_o,
    input logic sd_o,
    input logic cfg_pol,
    input logic pol_q,
    input logic ext_q
);
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready); // R2

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_RX_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> tx_ready); // R7

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && tx_ready && $past(tx_ready) && $stable(cfg_pol)
        |-> sck_o == cfg_pol); // R4

    AST_EXT_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready && ext_q |-> sck_o == pol_q); // R8

    AST_SD_ON_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready && !ext_q && !$stable(sd_o) |-> sck_o != pol_q); // R5
endmodule

bind gated_serial_port gsp_checker i_gsp_checker (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .sck_o(sck_o), .sd_o(sd_o), .cfg_pol(cfg_pol),
    .pol_q(pol_q), .ext_q(ext_q)
);

// File: tb/test_gated_serial_port.sv
module test_gated_serial_port;
    localparam int W  = 8;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ext = 1'b0, cfg_pol = 1'b0;
    logic [DW-1:0] cfg_half_div = '0;
    logic [W-1:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready, rx_valid, sck_o, sd_o;
    logic [W-1:0] rx_data;
    logic sck_i = 1'b0;
    logic sd_i_ext = 1'b0;
    logic sd_i_int;
    logic sd_i;
    assign sd_i = cfg_ext ? sd_i_ext : sd_i_int;

    always #5 clk = ~clk;

    gated_serial_port #(.WORD_W(W), .DIV_W(DW)) i_gated_serial_port (
        .clk(clk), .rst_n(rst_n), .cfg_ext(cfg_ext), .cfg_pol(cfg_pol),
        .cfg_half_div(cfg_half_div), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .sck_o(sck_o), .sck_i(sck_i), .sd_o(sd_o), .sd_i(sd_i)
    );

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // clock-line monitor and internal-mode slave
    logic mon_clr = 1'b0;
    logic mon_pol = 1'b0;
    int   mon_h = 1;
    logic [2*W-1:0] slave_pat = '0;
    logic sck_prev = 1'b0;
    int lead_cnt = 0, act_cnt = 0, rest_cnt = 0, width_err = 0, rest_err = 0, rxv_cnt = 0;
    logic [2*W-1:0] tx_cap = '0;
    logic [2*W-1:0] rx_hist = '0;
    logic [W-1:0] rx_last = '0;
    logic sd_i_q = 1'b0;
    assign sd_i_int = sd_i_q;

    always @(negedge clk) begin
        sck_prev <= sck_o;
        if (mon_clr) begin
            lead_cnt <= 0; act_cnt <= 0; rest_cnt <= 0;
            width_err <= 0; rest_err <= 0; rxv_cnt <= 0;
            tx_cap <= '0; rx_hist <= '0;
        end else begin
            if (sck_o != sck_prev && sck_o != mon_pol) begin
                tx_cap   <= {tx_cap[2*W-2:0], sd_o};
                if (lead_cnt < 2*W) sd_i_q <= slave_pat[2*W-1-lead_cnt];
                if (lead_cnt > 0 && rest_cnt != mon_h) rest_err <= rest_err + 1;
                lead_cnt <= lead_cnt + 1;
                act_cnt  <= 1;
            end else if (sck_o != sck_prev) begin
                if (act_cnt != mon_h) width_err <= width_err + 1;
                rest_cnt <= 1;
            end else if (sck_o != mon_pol) begin
                act_cnt <= act_cnt + 1;
            end else begin
                rest_cnt <= rest_cnt + 1;
            end
            if (rx_valid) begin
                rxv_cnt <= rxv_cnt + 1;
                rx_last <= rx_data;
                rx_hist <= {rx_hist[W-1:0], rx_data};
            end
        end
    end

    task automatic prep(input logic ext, input logic pol, input logic [DW-1:0] half,
                        input logic [2*W-1:0] pat);
        @(negedge clk);
        cfg_ext = ext; cfg_pol = pol; cfg_half_div = half; sck_i = pol;
        repeat (5) @(negedge clk);
        mon_pol = pol; mon_h = (half == 0) ? 1 : int'(half); slave_pat = pat; mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic offer(input logic [W-1:0] d);
        tx_data = d; tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        for (int t = 0; t < 3000 && rxv_cnt < n; t++) @(negedge clk);
    endtask

    task automatic int_word(input logic pol, input logic [DW-1:0] half,
                            input logic [W-1:0] txw, input logic [W-1:0] slw);
        prep(1'b0, pol, half, {slw, {W{1'b0}}});
        offer(txw);
        chk("R2 ready low after accept", tx_ready, 1'b0);
        wait_rx(1);
        repeat (4) @(negedge clk);
        chk("R3 pulse count", lead_cnt, W);
        chk("R3 active width", width_err, 0);
        chk("R3 idle gap", rest_err, 0);
        chk("R6 msb first out", tx_cap[W-1:0], txw);
        chk("R5 trailing-edge sampling", rx_last, slw);
        chk("R7 single strobe", rxv_cnt, 1);
        chk("R4 idle level", sck_o, pol);
        chk("R2 ready back", tx_ready, 1'b1);
    endtask

    task automatic ext_word(input logic pol, input logic [W-1:0] txw, input logic [W-1:0] slw);
        logic [W-1:0] got;
        got = '0;
        prep(1'b1, pol, '0, '0);
        offer(txw);
        repeat (4) @(negedge clk);
        for (int b = 0; b < W; b++) begin
            sck_i = ~pol; sd_i_ext = slw[W-1-b];
            repeat (4) @(negedge clk);
            got = {got[W-2:0], sd_o};
            sck_i = pol;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R8 bits launched on leading edges", got, txw);
        chk("R8 received word", rx_last, slw);
        chk("R7 single strobe ext", rxv_cnt, 1);
        chk("R8 sck_o stays idle", lead_cnt, 0);
        chk("R8 ready back", tx_ready, 1'b1);
    endtask

    // {ext, pol, half[3:0], tx[7:0], slave[7:0]}
    localparam logic [21:0] VECS [8] = '{
        {1'b0, 1'b0, 4'd1,  8'hA5, 8'h3C},
        {1'b0, 1'b1, 4'd1,  8'h5A, 8'hC3},
        {1'b0, 1'b0, 4'd0,  8'h81, 8'h7E},
        {1'b0, 1'b1, 4'd2,  8'hFF, 8'h00},
        {1'b0, 1'b0, 4'd15, 8'h01, 8'h80},
        {1'b1, 1'b0, 4'd0,  8'hB4, 8'h2D},
        {1'b1, 1'b1, 4'd0,  8'h6E, 8'h91},
        {1'b1, 1'b0, 4'd0,  8'h00, 8'hFF}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset tx_ready", tx_ready, 1'b1);
        chk("R1 reset rx_valid", rx_valid, 1'b0);
        chk("R1 reset sd_o", sd_o, 1'b0);
        chk("R1 reset sck_o", sck_o, 1'b0);

        for (int v = 0; v < 8; v++) begin
            if (VECS[v][21]) ext_word(VECS[v][20], VECS[v][15:8], VECS[v][7:0]);
            else             int_word(VECS[v][20], VECS[v][19:16], VECS[v][15:8], VECS[v][7:0]);
        end

        // R9: edges on sck_i with no word accepted
        prep(1'b1, 1'b0, '0, '0);
        for (int p = 0; p < 6; p++) begin
            sck_i = 1'b1; repeat (4) @(negedge clk);
            chk("R9 ready stays high", tx_ready, 1'b1);
            sck_i = 1'b0; repeat (4) @(negedge clk);
        end
        chk("R9 no strobe on idle edges", rxv_cnt, 0);
        ext_word(1'b0, 8'hC9, 8'h36);
        chk("R9 word after idle edges", rx_last, 8'h36);

        // R2: second word held on the handshake during a transfer
        prep(1'b0, 1'b0, 4'd1, {8'h5C, 8'hE1});
        tx_data = 8'h9D; tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_data = 8'h42;
        chk("R2 ready low while busy", tx_ready, 1'b0);
        repeat (6) @(negedge clk);
        chk("R2 ready low mid word", tx_ready, 1'b0);
        for (int t = 0; t < 3000 && !tx_ready; t++) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        wait_rx(2);
        repeat (4) @(negedge clk);
        chk("R2 both words sent", tx_cap, {8'h9D, 8'h42});
        chk("R2 pulse total", lead_cnt, 2*W);
        chk("R2 both words received", rx_hist, {8'h5C, 8'hE1});

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule